// File: doc/BRIEF.md
# Security Policy Bus Access Filter

This block sits on the request path between a group of bus initiators and a shared target address space. Every request carries an initiator number, an address, a direction, a privilege bit and write data. The filter decides in the same cycle whether the request may reach the target. It bases that decision on fixed, parameterised address windows and on live system status: debug mode, an ongoing key transfer, crypto engine activity and crypto reset. A denied write never reaches the target, and a denied read returns zeros.

Any refused request raises a sticky violation indicator and records the initiator number and address of the first offender. Only a privileged write of one to bit 0 at the filter's own control address clears it. A second, independent gate accepts clock-frequency change requests from the power manager only while the target core is idle.

Default windows: kernel 0x1000–0x1FFF, secure 0x2000–0x2FFF, crypto key 0x3000–0x30FF, crypto data 0x3100–0x31FF, crypto result 0x3200–0x32FF, and the control address 0x3F00. The default key-transfer initiator is 2.

Top module: `busGuard`

## Requirements
- R1: A request with reqPriv=0 that targets the kernel window, or the control address, is denied.
- R2: While keyXferActive=1, every request whose reqId differs from the key-transfer initiator is denied.
- R3: While cryptoBusy=1, the filter denies reads of the result window, writes to the key window, and any access to the data window. Key-window reads and result-window writes are still granted.
- R4: While cryptoReset=1, the same three prohibitions as in R3 apply.
- R5: While dbgMode=1, any access to the secure window is denied, whatever the privilege.
- R6: pmFreqAck=1 only when pmFreqReq=1 and coreActive=0. pmFreqNak=1 when pmFreqReq=1 and coreActive=1. Both are 0 without a request.
- R7: For a denied request, tgtWrEn=0, tgtRdEn=0 and rspRdata=0. For a granted read, rspRdata equals tgtRdata in the same cycle. Reads of the control address are always denied.
- R8: With reqValid=1, exactly one of reqGrant and reqDeny is 1 in the same cycle. With reqValid=0, both are 0.
- R9: A denial sets violFlag in the next cycle and captures reqId and reqAddr. While violFlag=1, later denials leave the captured values unchanged.
- R10: A granted write to the control address with reqPriv=1 and reqWdata[0]=1 clears violFlag, violId and violAddr in the next cycle and is not forwarded to the target. An unprivileged attempt is denied and clears nothing.
- R11: The key-transfer initiator itself is not blocked by the key-transfer lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqId | input | IDW | Initiator number |
| reqAddr | input | AW | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPriv | input | 1 | 1 = privileged, 0 = user |
| reqWdata | input | DW | Write data |
| dbgMode | input | 1 | Debug mode active |
| cryptoBusy | input | 1 | Crypto operation running |
| cryptoReset | input | 1 | Crypto reset active |
| keyXferActive | input | 1 | Key transfer into crypto registers in progress |
| coreActive | input | 1 | Target core in active mode |
| pmFreqReq | input | 1 | Power manager frequency change request |
| tgtRdata | input | DW | Read data from target |
| reqGrant | output | 1 | Request accepted |
| reqDeny | output | 1 | Request refused |
| tgtWrEn | output | 1 | Write forwarded to target |
| tgtRdEn | output | 1 | Read forwarded to target |
| tgtAddr | output | AW | Address to target |
| tgtWdata | output | DW | Write data to target |
| rspRdata | output | DW | Read data returned to initiator |
| pmFreqAck | output | 1 | Frequency change accepted |
| pmFreqNak | output | 1 | Frequency change refused |
| violFlag | output | 1 | Sticky violation indicator |
| violId | output | IDW | Captured offending initiator |
| violAddr | output | AW | Captured offending address |

## Verification
Requests are aimed at each window in turn: once with every status input low, and again with each status input raised on its own. This separates the rules from one another. For example, a key-window read under cryptoBusy must pass while a key-window write must fail. The key-transfer phase is tried with the exempt initiator and with another initiator. This shows that the lockout keys on the initiator number and not on the address. Sequences of a first denial, a second denial, an unprivileged clear and a privileged clear tell apart first-offender capture, overwrite and premature clearing.

// File: rtl/busGuardPkg.sv
package busGuardPkg;
  typedef struct packed {
    logic grant;
    logic deny;
    logic fwdWr;
    logic fwdRd;
    logic setViol;
    logic clrViol;
  } guardStrobeT;
endpackage

// File: rtl/busGuardCtrl.sv
module busGuardCtrl
  import busGuardPkg::*;
#(
  parameter int AW = 16,
  parameter int IDW = 3,
  parameter logic [AW-1:0] KERN_LO = 'h1000,
  parameter logic [AW-1:0] KERN_HI = 'h1FFF,
  parameter logic [AW-1:0] SEC_LO = 'h2000,
  parameter logic [AW-1:0] SEC_HI = 'h2FFF,
  parameter logic [AW-1:0] KEY_LO = 'h3000,
  parameter logic [AW-1:0] KEY_HI = 'h30FF,
  parameter logic [AW-1:0] DAT_LO = 'h3100,
  parameter logic [AW-1:0] DAT_HI = 'h31FF,
  parameter logic [AW-1:0] RES_LO = 'h3200,
  parameter logic [AW-1:0] RES_HI = 'h32FF,
  parameter logic [AW-1:0] GUARD_ADDR = 'h3F00,
  parameter logic [IDW-1:0] KEY_ID = 'd2
) (
  input  logic           reqValid,
  input  logic [IDW-1:0] reqId,
  input  logic [AW-1:0]  reqAddr,
  input  logic           reqWrite,
  input  logic           reqPriv,
  input  logic           clrBit,
  input  logic           dbgMode,
  input  logic           cryptoBusy,
  input  logic           cryptoReset,
  input  logic           keyXferActive,
  input  logic           coreActive,
  input  logic           pmFreqReq,
  output guardStrobeT    strb,
  output logic           pmFreqAck,
  output logic           pmFreqNak
);
  function automatic logic inWin(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                 input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic inKern, inSec, inKey, inDat, inRes, isGuard, cryptoHold;
  logic denyUser, denyXfer, denyCrypto, denyDbg, denyGuardRd, anyDeny;

  always_comb begin
    inKern     = inWin(reqAddr, KERN_LO, KERN_HI);
    inSec      = inWin(reqAddr, SEC_LO, SEC_HI);
    inKey      = inWin(reqAddr, KEY_LO, KEY_HI);
    inDat      = inWin(reqAddr, DAT_LO, DAT_HI);
    inRes      = inWin(reqAddr, RES_LO, RES_HI);
    isGuard    = (reqAddr == GUARD_ADDR);
    cryptoHold = cryptoBusy | cryptoReset;

    denyUser    = !reqPriv && (inKern || isGuard);
    denyXfer    = keyXferActive && (reqId != KEY_ID);
    denyCrypto  = cryptoHold && ((inRes && !reqWrite) || (inKey && reqWrite) || inDat);
    denyDbg     = dbgMode && inSec;
    denyGuardRd = isGuard && !reqWrite;
    anyDeny     = denyUser | denyXfer | denyCrypto | denyDbg | denyGuardRd;

    strb.deny    = reqValid && anyDeny;
    strb.grant   = reqValid && !anyDeny;
    strb.fwdWr   = strb.grant && reqWrite && !isGuard;
    strb.fwdRd   = strb.grant && !reqWrite;
    strb.setViol = strb.deny;
    strb.clrViol = strb.grant && reqWrite && isGuard && clrBit;

    pmFreqAck = pmFreqReq && !coreActive;
    pmFreqNak = pmFreqReq && coreActive;
  end
endmodule

// File: rtl/busGuardDatapath.sv
module busGuardDatapath
  import busGuardPkg::*;
#(
  parameter int AW = 16,
  parameter int IDW = 3,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  guardStrobeT    strb,
  input  logic [IDW-1:0] reqId,
  input  logic [AW-1:0]  reqAddr,
  input  logic [DW-1:0]  tgtRdata,
  output logic [DW-1:0]  rspRdata,
  output logic           violFlag,
  output logic [IDW-1:0] violId,
  output logic [AW-1:0]  violAddr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violFlag <= 1'b0;
      violId   <= '0;
      violAddr <= '0;
    end else if (strb.clrViol) begin
      violFlag <= 1'b0;
      violId   <= '0;
      violAddr <= '0;
    end else if (strb.setViol && !violFlag) begin
      violFlag <= 1'b1;
      violId   <= reqId;
      violAddr <= reqAddr;
    end
  end

  assign rspRdata = strb.fwdRd ? tgtRdata : '0;
endmodule

// File: rtl/busGuard.sv
module busGuard
  import busGuardPkg::*;
#(
  parameter int AW = 16,
  parameter int IDW = 3,
  parameter int DW = 32,
  parameter logic [AW-1:0] KERN_LO = 'h1000,
  parameter logic [AW-1:0] KERN_HI = 'h1FFF,
  parameter logic [AW-1:0] SEC_LO = 'h2000,
  parameter logic [AW-1:0] SEC_HI = 'h2FFF,
  parameter logic [AW-1:0] KEY_LO = 'h3000,
  parameter logic [AW-1:0] KEY_HI = 'h30FF,
  parameter logic [AW-1:0] DAT_LO = 'h3100,
  parameter logic [AW-1:0] DAT_HI = 'h31FF,
  parameter logic [AW-1:0] RES_LO = 'h3200,
  parameter logic [AW-1:0] RES_HI = 'h32FF,
  parameter logic [AW-1:0] GUARD_ADDR = 'h3F00,
  parameter logic [IDW-1:0] KEY_ID = 'd2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic [IDW-1:0] reqId,
  input  logic [AW-1:0]  reqAddr,
  input  logic           reqWrite,
  input  logic           reqPriv,
  input  logic [DW-1:0]  reqWdata,
  input  logic           dbgMode,
  input  logic           cryptoBusy,
  input  logic           cryptoReset,
  input  logic           keyXferActive,
  input  logic           coreActive,
  input  logic           pmFreqReq,
  input  logic [DW-1:0]  tgtRdata,
  output logic           reqGrant,
  output logic           reqDeny,
  output logic           tgtWrEn,
  output logic           tgtRdEn,
  output logic [AW-1:0]  tgtAddr,
  output logic [DW-1:0]  tgtWdata,
  output logic [DW-1:0]  rspRdata,
  output logic           pmFreqAck,
  output logic           pmFreqNak,
  output logic           violFlag,
  output logic [IDW-1:0] violId,
  output logic [AW-1:0]  violAddr
);
  guardStrobeT strb;

  busGuardCtrl #(
    .AW(AW), .IDW(IDW), .KERN_LO(KERN_LO), .KERN_HI(KERN_HI), .SEC_LO(SEC_LO),
    .SEC_HI(SEC_HI), .KEY_LO(KEY_LO), .KEY_HI(KEY_HI), .DAT_LO(DAT_LO),
    .DAT_HI(DAT_HI), .RES_LO(RES_LO), .RES_HI(RES_HI), .GUARD_ADDR(GUARD_ADDR),
    .KEY_ID(KEY_ID)
  ) u_ctrl (
    .reqValid(reqValid), .reqId(reqId), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqPriv(reqPriv), .clrBit(reqWdata[0]), .dbgMode(dbgMode),
    .cryptoBusy(cryptoBusy), .cryptoReset(cryptoReset),
    .keyXferActive(keyXferActive), .coreActive(coreActive),
    .pmFreqReq(pmFreqReq), .strb(strb), .pmFreqAck(pmFreqAck),
    .pmFreqNak(pmFreqNak)
  );

  busGuardDatapath #(.AW(AW), .IDW(IDW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqId(reqId), .reqAddr(reqAddr),
    .tgtRdata(tgtRdata), .rspRdata(rspRdata), .violFlag(violFlag),
    .violId(violId), .violAddr(violAddr)
  );

  assign reqGrant = strb.grant;
  assign reqDeny  = strb.deny;
  assign tgtWrEn  = strb.fwdWr;
  assign tgtRdEn  = strb.fwdRd;
  assign tgtAddr  = reqAddr;
  assign tgtWdata = reqWdata;
endmodule

// File: rtl/busGuardChecker.sv
module busGuardChecker #(
  parameter int AW = 16,
  parameter int IDW = 3,
  parameter int DW = 32,
  parameter logic [AW-1:0] SEC_LO = 'h2000,
  parameter logic [AW-1:0] SEC_HI = 'h2FFF,
  parameter logic [AW-1:0] GUARD_ADDR = 'h3F00,
  parameter logic [IDW-1:0] KEY_ID = 'd2
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic [IDW-1:0] reqId,
  input logic [AW-1:0]  reqAddr,
  input logic           reqWrite,
  input logic           reqPriv,
  input logic [DW-1:0]  reqWdata,
  input logic           dbgMode,
  input logic           keyXferActive,
  input logic           coreActive,
  input logic           pmFreqReq,
  input logic           reqGrant,
  input logic           reqDeny,
  input logic           tgtWrEn,
  input logic           tgtRdEn,
  input logic [DW-1:0]  rspRdata,
  input logic           pmFreqAck,
  input logic           violFlag,
  input logic [IDW-1:0] violId,
  input logic [AW-1:0]  violAddr
);
  logic clrTry;
  assign clrTry = reqValid && reqWrite && reqPriv && (reqAddr == GUARD_ADDR) && reqWdata[0];

  a_r8_one_decision: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($countones({reqGrant, reqDeny}) == 1));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!reqGrant && !reqDeny));
  a_r7_block_deny: assert property (@(posedge clk) disable iff (!rstN)
    reqDeny |-> (!tgtWrEn && !tgtRdEn && rspRdata == '0));
  a_r2_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && keyXferActive && reqId != KEY_ID) |-> reqDeny);
  a_r5_debug_secure: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && dbgMode && reqAddr >= SEC_LO && reqAddr <= SEC_HI) |-> reqDeny);
  a_r6_freq_gate: assert property (@(posedge clk) disable iff (!rstN)
    (pmFreqReq && coreActive) |-> !pmFreqAck);
  a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rstN)
    reqDeny |=> violFlag);
  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    (violFlag && !clrTry) |=> (violFlag && $stable(violId) && $stable(violAddr)));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrTry && reqGrant) |=> !violFlag);
endmodule

bind busGuard busGuardChecker #(
  .AW(AW), .IDW(IDW), .DW(DW), .SEC_LO(SEC_LO), .SEC_HI(SEC_HI),
  .GUARD_ADDR(GUARD_ADDR), .KEY_ID(KEY_ID)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId), .reqAddr(reqAddr),
  .reqWrite(reqWrite), .reqPriv(reqPriv), .reqWdata(reqWdata), .dbgMode(dbgMode),
  .keyXferActive(keyXferActive), .coreActive(coreActive), .pmFreqReq(pmFreqReq),
  .reqGrant(reqGrant), .reqDeny(reqDeny), .tgtWrEn(tgtWrEn), .tgtRdEn(tgtRdEn),
  .rspRdata(rspRdata), .pmFreqAck(pmFreqAck), .violFlag(violFlag),
  .violId(violId), .violAddr(violAddr)
);

// File: tb/busGuard_bench.sv
module busGuard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IDW = 3;
  localparam int DW = 32;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, reqWrite = 0, reqPriv = 0;
  logic [IDW-1:0] reqId = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic dbgMode = 0, cryptoBusy = 0, cryptoReset = 0, keyXferActive = 0;
  logic coreActive = 0, pmFreqReq = 0;
  logic [DW-1:0] tgtRdata = 32'hA5A5_0F0F;
  logic reqGrant, reqDeny, tgtWrEn, tgtRdEn, pmFreqAck, pmFreqNak, violFlag;
  logic [AW-1:0] tgtAddr, violAddr;
  logic [DW-1:0] tgtWdata, rspRdata;
  logic [IDW-1:0] violId;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  bit mFlag = 0;
  int mId = 0;
  int mAddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busGuard u_busGuard (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit refDeny();
    int a = int'(reqAddr);
    bit kern = (a >= 'h1000 && a <= 'h1FFF);
    bit sec  = (a >= 'h2000 && a <= 'h2FFF);
    bit key  = (a >= 'h3000 && a <= 'h30FF);
    bit dat  = (a >= 'h3100 && a <= 'h31FF);
    bit res  = (a >= 'h3200 && a <= 'h32FF);
    bit grd  = (a == 'h3F00);
    bit hold = cryptoBusy || cryptoReset;
    if (!reqPriv && (kern || grd)) return 1;            // R1
    if (keyXferActive && reqId != 3'd2) return 1;       // R2 / R11
    if (hold && dat) return 1;                          // R3 / R4
    if (hold && key && reqWrite) return 1;
    if (hold && res && !reqWrite) return 1;
    if (dbgMode && sec) return 1;                       // R5
    if (grd && !reqWrite) return 1;                     // R7
    return 0;
  endfunction

  // one cycle: inputs already driven at negedge
  task automatic cyc(input string tag);
    bit d, g, grd;
    #1;
    d   = reqValid && refDeny();
    g   = reqValid && !d;
    grd = (reqAddr == 16'h3F00);
    chk(tag, "reqDeny", int'(reqDeny), int'(d));
    chk(tag, "reqGrant", int'(reqGrant), int'(g));
    chk(tag, "tgtWrEn", int'(tgtWrEn), int'(g && reqWrite && !grd));
    chk(tag, "tgtRdEn", int'(tgtRdEn), int'(g && !reqWrite));
    chk(tag, "rspRdata", int'(rspRdata), (g && !reqWrite) ? int'(tgtRdata) : 0);
    chk("R6", "pmFreqAck", int'(pmFreqAck), int'(pmFreqReq && !coreActive));
    chk("R6", "pmFreqNak", int'(pmFreqNak), int'(pmFreqReq && coreActive));
    chk("R9", "violFlag", int'(violFlag), int'(mFlag));
    chk("R9", "violId", int'(violId), mId);
    chk("R9", "violAddr", int'(violAddr), mAddr);
    @(posedge clk);
    if (g && reqWrite && grd && reqWdata[0]) begin
      mFlag = 0; mId = 0; mAddr = 0;
    end else if (d && !mFlag) begin
      mFlag = 1; mId = int'(reqId); mAddr = int'(reqAddr);
    end
    @(negedge clk);
  endtask

  task automatic req(input int id, input int addr, input bit wr, input bit priv,
                     input int wd, input string tag);
    reqValid = 1; reqId = IDW'(id); reqAddr = AW'(addr);
    reqWrite = wr; reqPriv = priv; reqWdata = DW'(wd);
    cyc(tag);
    reqValid = 0;
  endtask

  task automatic clearViol();
    req(0, 'h3F00, 1, 1, 1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R9", "reset violFlag", int'(violFlag), 0);
    chk("R8", "reset reqGrant", int'(reqGrant), 0);
    rstN = 1;
    @(negedge clk);
    cyc("R8");                                     // idle
    // R1 user vs privileged kernel access
    req(1, 'h1004, 0, 0, 0, "R1");
    req(1, 'h1004, 0, 1, 0, "R7");
    req(3, 'h1800, 1, 0, 7, "R1");                 // second deny, capture held (R9)
    req(4, 'h0100, 1, 0, 5, "R7");                 // plain user write granted
    req(5, 'h3F00, 1, 0, 1, "R10");                // unprivileged clear refused
    req(0, 'h3F00, 0, 1, 0, "R7");                 // control read refused
    clearViol();
    cyc("R10");
    req(0, 'h3F00, 1, 1, 0, "R10");                // bit0 zero: no clear effect, nothing set
    // R2 / R11 key transfer lockout
    keyXferActive = 1;
    req(2, 'h3000, 1, 1, 9, "R11");
    req(2, 'h0200, 0, 0, 0, "R11");
    req(0, 'h0200, 0, 1, 0, "R2");
    req(6, 'h3000, 1, 1, 0, "R2");
    keyXferActive = 0;
    req(0, 'h0200, 0, 1, 0, "R2");
    clearViol();
    // R3 crypto busy
    cryptoBusy = 1;
    req(1, 'h3200, 0, 1, 0, "R3");
    req(1, 'h3210, 1, 1, 0, "R3");
    req(1, 'h3004, 0, 1, 0, "R3");
    req(1, 'h3004, 1, 1, 0, "R3");
    req(1, 'h3100, 0, 1, 0, "R3");
    req(1, 'h31FF, 1, 1, 0, "R3");
    cryptoBusy = 0;
    req(1, 'h3100, 1, 1, 0, "R3");
    clearViol();
    // R4 crypto reset
    cryptoReset = 1;
    req(3, 'h3280, 0, 1, 0, "R4");
    req(3, 'h30FF, 1, 1, 0, "R4");
    req(3, 'h3180, 0, 1, 0, "R4");
    req(3, 'h3000, 0, 1, 0, "R4");
    cryptoReset = 0;
    clearViol();
    // R5 debug mode
    dbgMode = 1;
    req(4, 'h2000, 0, 1, 0, "R5");
    req(4, 'h2FFF, 1, 1, 0, "R5");
    req(4, 'h1000, 0, 1, 0, "R5");
    dbgMode = 0;
    req(4, 'h2000, 0, 1, 0, "R5");
    clearViol();
    // R6 frequency gate
    pmFreqReq = 1; coreActive = 1; cyc("R6");
    coreActive = 0; cyc("R6");
    pmFreqReq = 0; cyc("R6");
    // R7 different read data
    tgtRdata = 32'h1234_5678;
    req(2, 'h0400, 0, 0, 0, "R7");
    req(2, 'h1400, 0, 0, 0, "R7");
    cyc("R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule